// File: doc/BRIEF.md
# Interval Timer with Interrupt and Two Masked I/O Ports

This block sits on a small 8-bit processor bus and provides a one-shot interval timer, a timer interrupt flag, an active-high interrupt line and two general-purpose ports. Each port has a direction register. Software starts the timer by writing a count. The address of that write selects a clock prescaler and decides whether the expiry raises the interrupt line.

When the scaled interval has run out, the timer sets bit 7 of the flag register. It then enters a second phase that counts a fixed number of undivided clocks, after which it goes idle. A read of the timer returns a different value in each phase:

- idle: zero;
- first phase: the remaining cycles divided by the prescale;
- second phase: the raw remaining clocks.

Reading the flag register clears it and also clears the interrupt line. A separate write region stores a two-bit edge-control setting, which is held for neighbouring logic. Everything runs on one clock with an active-high synchronous reset.

Top module: `riot_timer`

## Requirements
- R1: After reset, both port data registers hold all ones, both direction registers hold zero, the timer is idle with prescale 1, the flag register reads zero, the interrupt is disabled and low, and the edge-control output is zero.
- R2: With address bit 2 low, address bits 1:0 select the register: 0 selects port A data, 1 port A direction, 2 port B data and 3 port B direction. A write stores into the selected register and a read returns it.
- R3: A write to a port data register changes only the bits whose direction bit is 1; every other bit keeps its old value.
- R4: A write with address bits 2 and 4 high starts the timer. The written byte N is the count. Address bits 1:0 select a prescale P of 2^0, 2^SHIFT_1, 2^SHIFT_2 or 2^SHIFT_3 (1, 8, 64, 1024 by default). Address bit 3 sets the interrupt enable. For N ≥ 1 the expiry takes effect on the N·P-th clock edge after the write edge; for N = 0 it takes effect on the next edge.
- R5: Starting the timer forces the interrupt line low. It also clears flag bit 7, except when the timer is still in its first phase.
- R6: On expiry, flag bit 7 is set and the interrupt line follows the interrupt enable. The timer then spends POST_LEN clock cycles in the second phase and then goes idle. The interrupt line is never high while flag bit 7 is clear.
- R7: A read with address bits 2 and 0 high returns the flag register, with the timer flag in bit 7 and zeros elsewhere. That read clears the flag and the interrupt line, unless an expiry falls on the same edge, in which case the expiry wins.
- R8: A read with address bit 2 high and bit 0 low returns the timer value: 0 when idle, the remaining cycles shifted right by the prescale shift in the first phase, and the remaining raw cycles in the second phase. The same read loads address bit 3 into the interrupt enable.
- R9: A write with address bit 2 high and bit 4 low stores address bits 1:0 on the edge-control output and leaves the timer untouched.
- R10: Read data is valid in the same cycle as the read strobe. The read's side effects take place at the clock edge that ends the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busAddr | input | 5 | Register address |
| busWrData | input | DATA_W | Write data |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busRdData | output | DATA_W | Read data, valid while busRd is high |
| irq | output | 1 | Timer interrupt, active high |
| portAData | output | DATA_W | Port A data register |
| portADir | output | DATA_W | Port A direction register (1 = driven) |
| portBData | output | DATA_W | Port B data register |
| portBDir | output | DATA_W | Port B direction register (1 = driven) |
| edgeSel | output | 2 | Stored edge-control setting |

## Verification
The bench builds the block with SHIFT_1 = 3, SHIFT_2 = 6, SHIFT_3 = 7 and POST_LEN = 16. Each prescale select then gives a distinct, small divisor, so the shifted timer read can be checked on every select within a few cycles. The short second phase lets the bench watch that phase run from its first raw value through to idle. It also lets the bench line up a flag read with the exact expiry edge.

// File: rtl/riot_timer_pkg.sv
package riot_timer_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_COUNT = 2'd1,
    PH_POST  = 2'd2
  } phase_t;

  // Strobes and decoded fields passed from control to datapath
  typedef struct packed {
    logic       ioSpace;    // address bit 2 low
    logic       flagSpace;  // address bit 0 (timer space only)
    logic [1:0] regSel;     // address bits 1:0
    logic       enBit;      // address bit 3
    logic       portWr;
    logic       timerStart;
    logic       keepFlag;   // start arrives during first phase
    logic       expire;
    logic       countDown;
    logic       postDone;
    logic       flagRd;
    logic       timerRd;
    logic       edgeWr;
  } strobe_t;

endpackage

// File: rtl/riot_timer_ctrl.sv
module riot_timer_ctrl
  import riot_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [4:0] addr,
  input  logic       rdEn,
  input  logic       wrEn,
  input  logic       remDone,
  output strobe_t    stb,
  output phase_t     phase
);

  always_comb begin
    stb            = '0;
    stb.ioSpace    = !addr[2];
    stb.flagSpace  = addr[0];
    stb.regSel     = addr[1:0];
    stb.enBit      = addr[3];
    stb.portWr     = wrEn && !addr[2];
    stb.timerStart = wrEn && addr[2] && addr[4];
    stb.edgeWr     = wrEn && addr[2] && !addr[4];
    stb.flagRd     = rdEn && addr[2] && addr[0];
    stb.timerRd    = rdEn && addr[2] && !addr[0];
    stb.keepFlag   = (phase == PH_COUNT);
    stb.expire     = !stb.timerStart && (phase == PH_COUNT) && remDone;
    stb.postDone   = !stb.timerStart && (phase == PH_POST) && remDone;
    stb.countDown  = !stb.timerStart && (phase != PH_IDLE) && !remDone;
  end

  always_ff @(posedge clk) begin
    if (rst)                 phase <= PH_IDLE;
    else if (stb.timerStart) phase <= PH_COUNT;
    else if (stb.expire)     phase <= PH_POST;
    else if (stb.postDone)   phase <= PH_IDLE;
  end

  // R4: an idle timer only leaves idle through a start write
  assert_idle_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE && !stb.timerStart) |=> (phase == PH_IDLE));

  // R6: expiry always enters the second phase
  assert_expire_to_post_R6: assert property (@(posedge clk) disable iff (rst)
    stb.expire |=> (phase == PH_POST));

endmodule

// File: rtl/riot_timer_dp.sv
module riot_timer_dp
  import riot_timer_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SHIFT_1  = 3,
  parameter int SHIFT_2  = 6,
  parameter int SHIFT_3  = 10,
  parameter int POST_LEN = 255
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] wrData,
  input  strobe_t           stb,
  input  phase_t            phase,
  output logic              remDone,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic [DATA_W-1:0] portAData,
  output logic [DATA_W-1:0] portADir,
  output logic [DATA_W-1:0] portBData,
  output logic [DATA_W-1:0] portBDir,
  output logic [1:0]        edgeSel
);

  localparam int REM_W    = DATA_W + SHIFT_3;
  localparam int NUM_PORT = 2;

  logic [DATA_W-1:0] portData [NUM_PORT];
  logic [DATA_W-1:0] portDir  [NUM_PORT];
  logic [REM_W-1:0]  rem;
  logic [1:0]        preSel;
  logic              timFlag;
  logic              irqReg;
  logic              irqEn;
  logic [1:0]        edgeReg;

  function automatic int shiftOf(input logic [1:0] s);
    case (s)
      2'd0:    return 0;
      2'd1:    return SHIFT_1;
      2'd2:    return SHIFT_2;
      default: return SHIFT_3;
    endcase
  endfunction

  assign remDone = (rem <= REM_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NUM_PORT; p++) begin
        portData[p] <= '1;
        portDir[p]  <= '0;
      end
      rem     <= '0;
      preSel  <= '0;
      timFlag <= 1'b0;
      irqReg  <= 1'b0;
      irqEn   <= 1'b0;
      edgeReg <= '0;
    end else begin
      if (stb.portWr) begin
        for (int p = 0; p < NUM_PORT; p++) begin
          if (stb.regSel[1] == p[0]) begin
            if (stb.regSel[0]) portDir[p] <= wrData;
            else portData[p] <= (portData[p] & ~portDir[p]) | (wrData & portDir[p]);
          end
        end
      end
      if (stb.edgeWr) edgeReg <= stb.regSel;
      if (stb.timerRd) irqEn <= stb.enBit;
      if (stb.timerStart) begin
        rem    <= REM_W'(wrData) << shiftOf(stb.regSel);
        preSel <= stb.regSel;
        irqEn  <= stb.enBit;
      end else if (stb.expire) begin
        rem <= REM_W'(POST_LEN);
      end else if (stb.postDone) begin
        rem <= '0;
      end else if (stb.countDown) begin
        rem <= rem - REM_W'(1);
      end
      if (stb.timerStart && !stb.keepFlag) timFlag <= 1'b0;
      if (stb.flagRd) timFlag <= 1'b0;
      if (stb.expire) timFlag <= 1'b1;
      if (stb.timerStart || stb.flagRd) irqReg <= 1'b0;
      if (stb.expire) irqReg <= irqEn;
    end
  end

  always_comb begin
    rdData = '1;
    if (stb.ioSpace) begin
      case (stb.regSel)
        2'd0:    rdData = portData[0];
        2'd1:    rdData = portDir[0];
        2'd2:    rdData = portData[1];
        default: rdData = portDir[1];
      endcase
    end else if (stb.flagSpace) begin
      rdData = {timFlag, {(DATA_W-1){1'b0}}};
    end else begin
      case (phase)
        PH_COUNT: rdData = DATA_W'(rem >> shiftOf(preSel));
        PH_POST:  rdData = DATA_W'(rem);
        default:  rdData = '0;
      endcase
    end
  end

  assign irq       = irqReg;
  assign portAData = portData[0];
  assign portADir  = portDir[0];
  assign portBData = portData[1];
  assign portBDir  = portDir[1];
  assign edgeSel   = edgeReg;

  // R3: input-direction bits of a port survive a data write
  assert_mask_port_a_R3: assert property (@(posedge clk) disable iff (rst)
    (stb.portWr && stb.regSel == 2'd0) |=>
      (((portData[0] ^ $past(portData[0])) & ~$past(portDir[0])) == '0));
  assert_mask_port_b_R3: assert property (@(posedge clk) disable iff (rst)
    (stb.portWr && stb.regSel == 2'd2) |=>
      (((portData[1] ^ $past(portData[1])) & ~$past(portDir[1])) == '0));

  // R5: a start write leaves the interrupt line low
  assert_start_clears_irq_R5: assert property (@(posedge clk) disable iff (rst)
    stb.timerStart |=> !irqReg);

  // R6: the interrupt line implies a set timer flag
  assert_irq_needs_flag_R6: assert property (@(posedge clk) disable iff (rst)
    irqReg |-> timFlag);

  // R6: second-phase count never exceeds its length
  assert_post_bound_R6: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_POST) |-> (rem <= REM_W'(POST_LEN)));

  // R7: a flag read without a coincident expiry clears the flag
  assert_flag_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (stb.flagRd && !stb.expire) |=> !timFlag);

endmodule

// File: rtl/riot_timer.sv
module riot_timer
  import riot_timer_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SHIFT_1  = 3,
  parameter int SHIFT_2  = 6,
  parameter int SHIFT_3  = 10,
  parameter int POST_LEN = 255
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [4:0]        busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRd,
  input  logic              busWr,
  output logic [DATA_W-1:0] busRdData,
  output logic              irq,
  output logic [DATA_W-1:0] portAData,
  output logic [DATA_W-1:0] portADir,
  output logic [DATA_W-1:0] portBData,
  output logic [DATA_W-1:0] portBDir,
  output logic [1:0]        edgeSel
);

  strobe_t stb;
  phase_t  phase;
  logic    remDone;

  riot_timer_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .addr    (busAddr),
    .rdEn    (busRd),
    .wrEn    (busWr),
    .remDone (remDone),
    .stb     (stb),
    .phase   (phase)
  );

  riot_timer_dp #(
    .DATA_W   (DATA_W),
    .SHIFT_1  (SHIFT_1),
    .SHIFT_2  (SHIFT_2),
    .SHIFT_3  (SHIFT_3),
    .POST_LEN (POST_LEN)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .wrData    (busWrData),
    .stb       (stb),
    .phase     (phase),
    .remDone   (remDone),
    .rdData    (busRdData),
    .irq       (irq),
    .portAData (portAData),
    .portADir  (portADir),
    .portBData (portBData),
    .portBDir  (portBDir),
    .edgeSel   (edgeSel)
  );

endmodule

// File: tb/tb_riot_timer.sv
module tb_riot_timer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic       busRd = 1'b0;
  logic       busWr = 1'b0;
  logic [7:0] busRdData;
  logic       irq;
  logic [7:0] portAData, portADir, portBData, portBDir;
  logic [1:0] edgeSel;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [7:0] v;

  always #5 clk = ~clk;

  riot_timer #(.DATA_W(8), .SHIFT_1(3), .SHIFT_2(6), .SHIFT_3(7), .POST_LEN(16)) dut (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWrData(busWrData),
    .busRd(busRd), .busWr(busWr), .busRdData(busRdData), .irq(irq),
    .portAData(portAData), .portADir(portADir), .portBData(portBData),
    .portBDir(portBDir), .edgeSel(edgeSel)
  );

  // {op, addr, data, expected}: op 0 = write, 1 = read and compare
  localparam logic [27:0] VEC [14] = '{
    28'h0_01_0F_00, 28'h0_00_00_00, 28'h1_00_00_F0, 28'h1_01_00_0F,
    28'h0_03_FF_00, 28'h0_02_5A_00, 28'h1_02_00_5A, 28'h0_03_00_00,
    28'h0_02_00_00, 28'h1_02_00_5A, 28'h0_01_F0_00, 28'h0_00_AB_00,
    28'h1_00_00_A0, 28'h1_03_00_00
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge; each consumes one rising edge
  task automatic busWrite(input logic [4:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [7:0] d);
    busAddr = a; busRd = 1'b1;
    #2 d = busRdData;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;

    // R1: reset state
    check("R1", {7'd0, irq}, 8'h00);
    check("R1", {6'd0, edgeSel}, 8'h00);
    busRead(5'h00, v); check("R1", v, 8'hFF);
    busRead(5'h01, v); check("R1", v, 8'h00);
    busRead(5'h02, v); check("R1", v, 8'hFF);
    busRead(5'h03, v); check("R1", v, 8'h00);
    busRead(5'h05, v); check("R1", v, 8'h00);
    busRead(5'h04, v); check("R1", v, 8'h00);

    // R2 and R3: port vectors
    for (int i = 0; i < 14; i++) begin
      if (VEC[i][24] == 1'b0) busWrite(VEC[i][20:16], VEC[i][15:8]);
      else begin
        busRead(VEC[i][20:16], v);
        check("R2/R3", v, VEC[i][7:0]);
      end
    end
    check("R3", portBData, 8'h5A);

    // R9: edge-control write
    busWrite(5'h06, 8'h00);
    check("R9", {6'd0, edgeSel}, 8'h02);
    check("R9", {7'd0, irq}, 8'h00);

    // R4/R6/R7/R8: count 3, prescale 1, interrupt enabled
    busWrite(5'h1C, 8'd3);
    idle(2); check("R4", {7'd0, irq}, 8'h00);
    idle(1); check("R6", {7'd0, irq}, 8'h01);
    busRead(5'h0C, v); check("R8", v, 8'd16);
    busRead(5'h05, v); check("R7", v, 8'h80);
    check("R7", {7'd0, irq}, 8'h00);
    busRead(5'h0C, v); check("R8", v, 8'd14);
    idle(20);
    busRead(5'h0C, v); check("R6", v, 8'h00);
    busRead(5'h05, v); check("R7", v, 8'h00);

    // R4/R10: count 5, prescale 8, interrupt disabled
    busWrite(5'h15, 8'd5);
    busRead(5'h04, v); check("R10", v, 8'd5);
    busRead(5'h04, v); check("R8", v, 8'd4);
    idle(37);
    busRead(5'h05, v); check("R7", v, 8'h00);  // expiry lands on this edge
    check("R6", {7'd0, irq}, 8'h00);
    busRead(5'h05, v); check("R7", v, 8'h80);

    // R4: count zero expires on the next edge
    busWrite(5'h1C, 8'd0);
    check("R5", {7'd0, irq}, 8'h00);
    idle(1); check("R4", {7'd0, irq}, 8'h01);

    // R5/R8: restart clears, timer read enables interrupt
    busWrite(5'h14, 8'd6);
    check("R5", {7'd0, irq}, 8'h00);
    busRead(5'h0C, v); check("R8", v, 8'd6);
    busRead(5'h05, v); check("R5", v, 8'h00);
    idle(3); check("R8", {7'd0, irq}, 8'h00);
    idle(1); check("R8", {7'd0, irq}, 8'h01);

    // R4: larger prescale selects
    busWrite(5'h16, 8'd3);
    busRead(5'h04, v); check("R4", v, 8'd3);
    busWrite(5'h17, 8'd2);
    busRead(5'h04, v); check("R4", v, 8'd2);
    busRead(5'h04, v); check("R4", v, 8'd1);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule